// File: doc/BRIEF.md
# SDRAM Controller with Per-Bank Open-Row Tracking

This block sits between a simple host request port and one rank of SDRAM. After reset it holds the device idle for a settling period, then brings it up with a fixed sequence: one precharge of every bank, eight auto-refresh cycles and a mode-register load. Only after that sequence ends does it accept host requests. Each request carries an address (bank, row, column), write data, byte enables, a read/write select and a flag that marks the access as sequential.

The controller keeps one open row per bank. A request to a row that is already open goes straight to READ or WRITE. A request to a bank with no open row first activates that row. A request to a bank with a different open row first precharges that bank and then activates the new row. A sequential request that follows an access at the last column of a page is always treated as a row change.

A refresh timer with a host-set interval raises a refresh request. The controller closes all banks, issues one auto-refresh and continues. If the interval runs out again while the last refresh request is still waiting, a sticky error output is raised until the host clears it.

Top module: `sdr_rowkeep_ctrl`

## Requirements
- R1: CKE goes high one cycle after reset release. The device sees only NOP until the first command, which is a precharge-all exactly T_INIT cycles after reset release. No ACTIVATE, READ or WRITE is issued before initialization is done.
- R2: Initialization runs in this order. A precharge with address bit 10 high comes first. Eight AUTO-REFRESH commands follow, the first one T_RP cycles after the precharge and each later one T_RC cycles after the one before. A MODE REGISTER SET comes T_RC after the eighth refresh, with bank 0 and an address word holding CAS_LAT in bits 6:4 and zero in every other bit. req_ready first goes high T_MRD-1 cycles after the MRS cycle.
- R3: The command on {cs_n, ras_n, cas_n, we_n} is encoded as NOP 0111, ACTIVATE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, AUTO-REFRESH 0001, MRS 0000. The output is NOP while reset is held.
- R4: A request to a bank with no open row issues ACTIVATE (bank, row on the address bus) in the cycle after acceptance. READ or WRITE follows T_RCD cycles later. The column sits on the low address bits and bit 10 is low.
- R5: A request whose bank holds its row open issues READ or WRITE in the cycle after acceptance, with no PRECHARGE or ACTIVATE. This holds for sequential and non-sequential requests alike.
- R6: A request to a bank whose open row differs issues the following, counted from the cycle after acceptance: a single-bank PRECHARGE (address all zero, so bit 10 is low), then ACTIVATE after T_RP cycles, then the access after a further T_RCD cycles.
- R7: If the previous access hit column 2^COL_W-1 and the new request is marked sequential, the controller runs the precharge, activate and access sequence even when the row matches. A non-sequential request in the same situation is a hit.
- R8: In a WRITE cycle, dq_oe is high, dq_out carries the request data and dqm equals the inverted byte enables. In a READ cycle, dqm is zero and dq_oe is low.
- R9: A READ on the bus in cycle k gives a one-cycle rd_valid in cycle k+CAS_LAT+1. rd_data then holds dq_in as sampled at the edge that starts that cycle.
- R10: After initialization, a refresh becomes due every ref_period cycles. It is serviced as precharge-all, then AUTO-REFRESH T_RP cycles later. All rows are closed afterwards, so the next access to any bank starts with ACTIVATE.
- R11: ref_err rises when the refresh interval expires while an earlier refresh is still waiting. It stays high until err_clr is sampled high. It stays low while refreshes keep up.
- R12: Each bank keeps its own open row. Opening a row in one bank does not close the row open in another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and device clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_period | input | REF_W | Refresh interval in cycles |
| err_clr | input | 1 | Clears the refresh error flag |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_seq | input | 1 | Request continues the previous access sequentially |
| req_addr | input | BANK_W+ROW_W+COL_W | {bank, row, column} |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Byte enables for a write |
| req_ready | output | 1 | Request accepted at the next edge when valid |
| rd_data | output | DATA_W | Read data |
| rd_valid | output | 1 | rd_data valid for this cycle |
| ref_err | output | 1 | Sticky missed-refresh flag |
| sd_cke | output | 1 | Clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank address |
| sd_addr | output | ROW_W | Row / column / mode address |
| sd_dqm | output | DATA_W/8 | Byte mask |
| sd_dq_out | output | DATA_W | Write data to the device |
| sd_dq_oe | output | 1 | Drive enable for sd_dq_out |
| sd_dq_in | input | DATA_W | Read data from the device |

## Verification
Every device command is counted in cycles from a fixed point. For a request, that point is the acceptance edge: the first command appears one cycle later, and each later command T_RP or T_RCD cycles after the one before. Read data is due CAS_LAT+1 cycles after the READ cycle. The bench logs each non-NOP command with its cycle number at the falling edge and compares the log with exact expected cycles. It also compares the number of logged commands, so that a stray precharge or activate is caught. Initialization and refresh timing are checked against exact sums of T_INIT, T_RP, T_RC and T_MRD. The sticky error is checked both after the interval expires and again after the cause is gone, before and after a clear.

// File: rtl/sdr_rowkeep_ctrl.sv
module sdr_rowkeep_ctrl #(
  parameter int DATA_W  = 16,
  parameter int BANK_W  = 2,
  parameter int ROW_W   = 13,
  parameter int COL_W   = 9,
  parameter int REF_W   = 16,
  parameter int T_INIT  = 10000,
  parameter int T_RP    = 3,
  parameter int T_RC    = 9,
  parameter int T_MRD   = 2,
  parameter int T_RCD   = 3,
  parameter int CAS_LAT = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [REF_W-1:0]              ref_period,
  input  logic                          err_clr,
  input  logic                          req_valid,
  input  logic                          req_write,
  input  logic                          req_seq,
  input  logic [BANK_W+ROW_W+COL_W-1:0] req_addr,
  input  logic [DATA_W-1:0]             req_wdata,
  input  logic [DATA_W/8-1:0]           req_be,
  output logic                          req_ready,
  output logic [DATA_W-1:0]             rd_data,
  output logic                          rd_valid,
  output logic                          ref_err,
  output logic                          sd_cke,
  output logic                          sd_cs_n,
  output logic                          sd_ras_n,
  output logic                          sd_cas_n,
  output logic                          sd_we_n,
  output logic [BANK_W-1:0]             sd_ba,
  output logic [ROW_W-1:0]              sd_addr,
  output logic [DATA_W/8-1:0]           sd_dqm,
  output logic [DATA_W-1:0]             sd_dq_out,
  output logic                          sd_dq_oe,
  input  logic [DATA_W-1:0]             sd_dq_in
);
  localparam int AW = BANK_W + ROW_W + COL_W;
  localparam int BW = DATA_W / 8;
  localparam int NB = 1 << BANK_W;
  localparam int TW = $clog2(T_INIT + T_RC + 2);
  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD  = 4'b0101,
                         C_WR  = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001,
                         C_MRS = 4'b0000;
  localparam logic [ROW_W-1:0] A10_ALL  = ROW_W'(1024);
  localparam logic [ROW_W-1:0] MODE_VAL = ROW_W'(CAS_LAT * 16);

  typedef enum logic [2:0] {ST_PWR, ST_IREF, ST_MRS, ST_IDLE, ST_ACT, ST_RW, ST_RREF} st_t;

  st_t st, n_st;
  logic [TW-1:0] tmr, n_tmr;
  logic [2:0] icnt, n_icnt;
  logic init_done, mrs_go;
  logic [REF_W-1:0] ref_cnt;
  logic ref_pend, clr_pend, expire;
  logic [NB-1:0] open_v;
  logic [ROW_W-1:0] open_row [NB];
  logic last_max;
  logic [CAS_LAT:0] rd_sh;

  logic r_wr;
  logic [BANK_W-1:0] r_ba;
  logic [ROW_W-1:0] r_row;
  logic [COL_W-1:0] r_col;
  logic [DATA_W-1:0] r_dq;
  logic [BW-1:0] r_be;

  logic [3:0] cmd_q, n_cmd;
  logic [BANK_W-1:0] ba_q, n_ba;
  logic [ROW_W-1:0] addr_q, n_addr;
  logic [DATA_W-1:0] dq_q, n_dq;
  logic oe_q, n_oe, cke_q;
  logic [BW-1:0] dqm_q, n_dqm;

  logic acc, set_open, clr_bank, clr_all;
  logic [BANK_W-1:0] op_ba;
  logic [ROW_W-1:0] op_row;
  logic do_rw, rw_wr;
  logic [BANK_W-1:0] rw_ba;
  logic [COL_W-1:0] rw_col;
  logic [DATA_W-1:0] rw_dq;
  logic [BW-1:0] rw_be;

  wire [BANK_W-1:0] q_ba  = req_addr[AW-1 -: BANK_W];
  wire [ROW_W-1:0]  q_row = req_addr[COL_W +: ROW_W];
  wire [COL_W-1:0]  q_col = req_addr[COL_W-1:0];
  wire q_hit = open_v[q_ba] && (open_row[q_ba] == q_row) && !(req_seq && last_max);
  wire [REF_W:0] cnt_nx = {1'b0, ref_cnt} + 1'b1;

  assign expire    = init_done && (cnt_nx >= {1'b0, ref_period});
  assign req_ready = (st == ST_IDLE) && (tmr == '0) && !ref_pend;
  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign sd_ba     = ba_q;
  assign sd_addr   = addr_q;
  assign sd_dq_out = dq_q;
  assign sd_dq_oe  = oe_q;
  assign sd_dqm    = dqm_q;
  assign sd_cke    = cke_q;

  always_comb begin
    n_st = st;  n_icnt = icnt;
    n_tmr = (tmr != '0) ? tmr - 1'b1 : '0;
    n_cmd = C_NOP;  n_ba = '0;  n_addr = '0;  n_dq = '0;  n_oe = 1'b0;  n_dqm = '1;
    acc = 1'b0;  set_open = 1'b0;  clr_bank = 1'b0;  clr_all = 1'b0;  clr_pend = 1'b0;
    mrs_go = 1'b0;  op_ba = r_ba;  op_row = r_row;
    do_rw = 1'b0;  rw_wr = r_wr;  rw_ba = r_ba;  rw_col = r_col;  rw_dq = r_dq;  rw_be = r_be;
    if (tmr == '0) begin
      unique case (st)
        ST_PWR: begin
          n_cmd = C_PRE;  n_addr = A10_ALL;  n_tmr = TW'(T_RP - 1);  n_st = ST_IREF;
        end
        ST_IREF: begin
          n_cmd = C_REF;  n_tmr = TW'(T_RC - 1);  n_icnt = icnt + 3'd1;
          if (icnt == 3'd7) n_st = ST_MRS;
        end
        ST_MRS: begin
          n_cmd = C_MRS;  n_addr = MODE_VAL;  n_tmr = TW'(T_MRD - 1);
          n_st = ST_IDLE;  mrs_go = 1'b1;
        end
        ST_IDLE: begin
          if (ref_pend) begin
            n_cmd = C_PRE;  n_addr = A10_ALL;  clr_all = 1'b1;
            n_tmr = TW'(T_RP - 1);  n_st = ST_RREF;
          end else if (req_valid) begin
            acc = 1'b1;
            if (q_hit) begin
              do_rw = 1'b1;  rw_wr = req_write;  rw_ba = q_ba;  rw_col = q_col;
              rw_dq = req_wdata;  rw_be = req_be;
            end else if (open_v[q_ba]) begin
              n_cmd = C_PRE;  n_ba = q_ba;  clr_bank = 1'b1;
              n_tmr = TW'(T_RP - 1);  n_st = ST_ACT;
            end else begin
              n_cmd = C_ACT;  n_ba = q_ba;  n_addr = q_row;
              set_open = 1'b1;  op_ba = q_ba;  op_row = q_row;
              n_tmr = TW'(T_RCD - 1);  n_st = ST_RW;
            end
          end
        end
        ST_ACT: begin
          n_cmd = C_ACT;  n_ba = r_ba;  n_addr = r_row;  set_open = 1'b1;
          n_tmr = TW'(T_RCD - 1);  n_st = ST_RW;
        end
        ST_RW: begin
          do_rw = 1'b1;  n_st = ST_IDLE;
        end
        ST_RREF: begin
          n_cmd = C_REF;  clr_pend = 1'b1;  n_tmr = TW'(T_RC - 1);  n_st = ST_IDLE;
        end
        default: n_st = ST_PWR;
      endcase
    end
    if (do_rw) begin
      n_cmd  = rw_wr ? C_WR : C_RD;
      n_ba   = rw_ba;
      n_addr = ROW_W'(rw_col);
      n_dq   = rw_wr ? rw_dq : '0;
      n_oe   = rw_wr;
      n_dqm  = rw_wr ? ~rw_be : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_PWR;  tmr <= TW'(T_INIT - 1);  icnt <= '0;  init_done <= 1'b0;
      cmd_q <= C_NOP;  ba_q <= '0;  addr_q <= '0;  dq_q <= '0;  oe_q <= 1'b0;
      dqm_q <= '1;  cke_q <= 1'b0;
      ref_cnt <= '0;  ref_pend <= 1'b0;  ref_err <= 1'b0;
      rd_sh <= '0;  rd_valid <= 1'b0;  rd_data <= '0;  last_max <= 1'b0;
      r_wr <= 1'b0;  r_ba <= '0;  r_row <= '0;  r_col <= '0;  r_dq <= '0;  r_be <= '0;
      open_v <= '0;
      for (int b = 0; b < NB; b++) open_row[b] <= '0;
    end else begin
      st <= n_st;  tmr <= n_tmr;  icnt <= n_icnt;  cke_q <= 1'b1;
      cmd_q <= n_cmd;  ba_q <= n_ba;  addr_q <= n_addr;  dq_q <= n_dq;
      oe_q <= n_oe;  dqm_q <= n_dqm;
      if (mrs_go) init_done <= 1'b1;
      if (init_done) ref_cnt <= expire ? '0 : ref_cnt + 1'b1;
      ref_pend <= (ref_pend && !clr_pend) || expire;
      ref_err  <= (ref_err && !err_clr) || (expire && ref_pend && !clr_pend);
      rd_sh    <= {rd_sh[CAS_LAT-1:0], n_cmd == C_RD};
      rd_valid <= rd_sh[CAS_LAT];
      if (rd_sh[CAS_LAT]) rd_data <= sd_dq_in;
      if (do_rw) last_max <= &rw_col;
      if (acc) begin
        r_wr <= req_write;  r_ba <= q_ba;  r_row <= q_row;  r_col <= q_col;
        r_dq <= req_wdata;  r_be <= req_be;
      end
      if (clr_all) open_v <= '0;
      if (clr_bank) open_v[q_ba] <= 1'b0;
      if (set_open) begin
        open_v[op_ba]   <= 1'b1;
        open_row[op_ba] <= op_row;
      end
    end
  end

  logic [3:0] chk_last;
  logic [TW-1:0] chk_gap;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_last <= C_NOP;  chk_gap <= '0;
    end else if (cmd_q != C_NOP) begin
      chk_last <= cmd_q;  chk_gap <= '0;
    end else if (chk_gap != '1) begin
      chk_gap <= chk_gap + 1'b1;
    end
  end

  assert_ref_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q != C_NOP && chk_last == C_REF) |-> (chk_gap >= TW'(T_RC - 1)));
  assert_mrs_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q != C_NOP && chk_last == C_MRS) |-> (chk_gap >= TW'(T_MRD - 1)));
  assert_pre_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q != C_NOP && chk_last == C_PRE) |-> (chk_gap >= TW'(T_RP - 1)));
  assert_act_to_rw_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_q == C_RD || cmd_q == C_WR) && chk_last == C_ACT) |-> (chk_gap >= TW'(T_RCD - 1)));
  assert_no_access_pre_init_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !(cmd_q == C_ACT || cmd_q == C_RD || cmd_q == C_WR));
  assert_cke_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sd_cke |=> sd_cke);
  assert_err_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_err && !err_clr) |=> ref_err);
endmodule

// File: tb/sdr_rowkeep_ctrl_bench.sv
module sdr_rowkeep_ctrl_bench;
  localparam int T_INIT = 40, T_RP = 3, T_RC = 7, T_MRD = 2, T_RCD = 2, CL = 2;
  localparam logic [3:0] NOP = 4'b0111, ACT = 4'b0011, RD = 4'b0101, WR = 4'b0100,
                         PRE = 4'b0010, REF = 4'b0001, MRS = 4'b0000;

  logic clk = 0, rst_n = 0;
  logic [15:0] ref_period = 16'hFFFF;
  logic err_clr = 0, req_valid = 0, req_write = 0, req_seq = 0;
  logic [23:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0] req_be = '0;
  logic req_ready, rd_valid, ref_err, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [15:0] rd_data, sd_dq_out, sd_dq_in = 16'h0;
  logic [1:0] sd_ba, sd_dqm;
  logic [12:0] sd_addr;

  sdr_rowkeep_ctrl #(.T_INIT(T_INIT), .T_RP(T_RP), .T_RC(T_RC), .T_MRD(T_MRD),
                     .T_RCD(T_RCD), .CAS_LAT(CL)) u_sdr_rowkeep_ctrl (
    .clk(clk), .rst_n(rst_n), .ref_period(ref_period), .err_clr(err_clr),
    .req_valid(req_valid), .req_write(req_write), .req_seq(req_seq), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .req_ready(req_ready), .rd_data(rd_data),
    .rd_valid(rd_valid), .ref_err(ref_err), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
    .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba),
    .sd_addr(sd_addr), .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe),
    .sd_dq_in(sd_dq_in));

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  logic [3:0] lg_cmd [256];
  logic [1:0] lg_ba [256];
  logic [12:0] lg_addr [256];
  int lg_cyc [256];
  logic [15:0] lg_dq [256];
  logic lg_oe [256];
  logic [1:0] lg_dqm [256];
  int lg_n = 0, rd_cyc = -1;
  logic [15:0] rd_val = '0;

  always @(negedge clk) begin
    if (rst_n && {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} != NOP && lg_n < 256) begin
      lg_cmd[lg_n] = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
      lg_ba[lg_n] = sd_ba;  lg_addr[lg_n] = sd_addr;  lg_cyc[lg_n] = cyc;
      lg_dq[lg_n] = sd_dq_out;  lg_oe[lg_n] = sd_dq_oe;  lg_dqm[lg_n] = sd_dqm;
      lg_n = lg_n + 1;
    end
    if (rd_valid) begin rd_cyc = cyc;  rd_val = rd_data; end
  end

  task automatic chk_eq(input string rq, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic expect_cmd(input int idx, input logic [3:0] code, input int ba,
                            input int addr, input int c, input string rq);
    chk_eq(rq, "entry present", idx < lg_n, 1);
    if (idx < lg_n) begin
      chk_eq(rq, "command code", lg_cmd[idx], code);
      chk_eq(rq, "bank", lg_ba[idx], ba);
      chk_eq(rq, "address", lg_addr[idx], addr);
      chk_eq(rq, "cycle", lg_cyc[idx], c);
    end
  endtask

  task automatic send(input bit wr, input bit seq, input int ba, input int row, input int col,
                      input int d, input int be, output int acc, output int start);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    start = lg_n;
    req_valid = 1;  req_write = wr;  req_seq = seq;
    req_addr = {ba[1:0], row[12:0], col[8:0]};
    req_wdata = d[15:0];  req_be = be[1:0];
    acc = cyc + 1;
    @(negedge clk);
    req_valid = 0;
    repeat (12) @(negedge clk);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk_eq("R3", "NOP in reset", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, NOP);
    chk_eq("R1", "cke in reset", sd_cke, 0);
    chk_eq("R2", "ready in reset", req_ready, 0);
    chk_eq("R11", "ref_err in reset", ref_err, 0);
    rst_n = 1;
  endtask

  task automatic t_init;
    int rc, m;
    @(negedge clk);
    chk_eq("R1", "cke after reset", sd_cke, 1);
    while (!req_ready && cyc < 400) @(negedge clk);
    rc = cyc;
    m = T_INIT + T_RP + 8 * T_RC;
    chk_eq("R2", "command count", lg_n, 10);
    expect_cmd(0, PRE, 0, 1024, T_INIT, "R1");
    for (int k = 0; k < 8; k++) expect_cmd(1 + k, REF, 0, 0, T_INIT + T_RP + k * T_RC, "R2");
    expect_cmd(9, MRS, 0, CL * 16, m, "R2");
    chk_eq("R2", "first ready cycle", rc, m + T_MRD - 1);
  endtask

  task automatic t_closed_write;
    int a, s;
    send(1, 0, 0, 5, 3, 16'hA5C3, 2'b01, a, s);
    chk_eq("R4", "commands for closed bank", lg_n - s, 2);
    expect_cmd(s, ACT, 0, 5, a, "R4");
    expect_cmd(s + 1, WR, 0, 3, a + T_RCD, "R4");
    chk_eq("R8", "write data", lg_dq[s + 1], 16'hA5C3);
    chk_eq("R8", "write oe", lg_oe[s + 1], 1);
    chk_eq("R8", "write dqm", lg_dqm[s + 1], 2'b10);
  endtask

  task automatic t_hit_read;
    int a, s;
    sd_dq_in = 16'h3C7E;
    rd_cyc = -1;
    send(0, 0, 0, 5, 4, 0, 0, a, s);
    chk_eq("R5", "commands for hit read", lg_n - s, 1);
    expect_cmd(s, RD, 0, 4, a, "R5");
    chk_eq("R8", "read dqm", lg_dqm[s], 0);
    chk_eq("R8", "read oe", lg_oe[s], 0);
    chk_eq("R9", "read data cycle", rd_cyc, a + CL + 1);
    chk_eq("R9", "read data", rd_val, 16'h3C7E);
    send(1, 1, 0, 5, 5, 16'h1111, 2'b11, a, s);
    chk_eq("R5", "commands for sequential hit", lg_n - s, 1);
    expect_cmd(s, WR, 0, 5, a, "R5");
  endtask

  task automatic t_miss;
    int a, s;
    send(1, 0, 0, 9, 0, 16'hBEEF, 2'b11, a, s);
    chk_eq("R6", "commands for row miss", lg_n - s, 3);
    expect_cmd(s, PRE, 0, 0, a, "R6");
    expect_cmd(s + 1, ACT, 0, 9, a + T_RP, "R6");
    expect_cmd(s + 2, WR, 0, 0, a + T_RP + T_RCD, "R6");
    chk_eq("R8", "write dqm all bytes", lg_dqm[s + 2], 0);
  endtask

  task automatic t_banks;
    int a, s;
    sd_dq_in = 16'h0F0F;
    send(0, 0, 1, 2, 7, 0, 0, a, s);
    chk_eq("R12", "other bank opens", lg_n - s, 2);
    expect_cmd(s, ACT, 1, 2, a, "R12");
    expect_cmd(s + 1, RD, 1, 7, a + T_RCD, "R12");
    chk_eq("R9", "read data bank1", rd_val, 16'h0F0F);
    chk_eq("R9", "read data cycle bank1", rd_cyc, a + T_RCD + CL + 1);
    send(0, 0, 0, 9, 8, 0, 0, a, s);
    chk_eq("R12", "bank0 row kept", lg_n - s, 1);
    expect_cmd(s, RD, 0, 8, a, "R12");
  endtask

  task automatic t_boundary;
    int a, s;
    send(1, 0, 0, 9, 511, 16'h0001, 2'b11, a, s);
    chk_eq("R7", "last column hit", lg_n - s, 1);
    send(1, 1, 0, 9, 0, 16'h0002, 2'b11, a, s);
    chk_eq("R7", "sequential after page end", lg_n - s, 3);
    expect_cmd(s, PRE, 0, 0, a, "R7");
    expect_cmd(s + 1, ACT, 0, 9, a + T_RP, "R7");
    expect_cmd(s + 2, WR, 0, 0, a + T_RP + T_RCD, "R7");
    send(1, 0, 0, 9, 511, 16'h0003, 2'b11, a, s);
    send(1, 0, 0, 9, 1, 16'h0004, 2'b11, a, s);
    chk_eq("R7", "non-sequential after page end hits", lg_n - s, 1);
    expect_cmd(s, WR, 0, 1, a, "R7");
  endtask

  task automatic t_refresh;
    int a, s, w;
    chk_eq("R11", "no error while refresh keeps up", ref_err, 0);
    @(negedge clk);
    s = lg_n;
    ref_period = 16'd100;
    w = 0;
    while (lg_n < s + 2 && w < 400) begin @(negedge clk); w++; end
    ref_period = 16'hFFFF;
    expect_cmd(s, PRE, 0, 1024, lg_cyc[s], "R10");
    expect_cmd(s + 1, REF, 0, 0, lg_cyc[s] + T_RP, "R10");
    repeat (T_RC + 2) @(negedge clk);
    send(0, 0, 1, 2, 7, 0, 0, a, s);
    chk_eq("R10", "row closed by refresh", lg_n - s, 2);
    expect_cmd(s, ACT, 1, 2, a, "R10");
    chk_eq("R11", "no error after one refresh", ref_err, 0);
  endtask

  task automatic t_err;
    @(negedge clk);
    ref_period = 16'd4;
    repeat (60) @(negedge clk);
    chk_eq("R11", "error on missed deadline", ref_err, 1);
    ref_period = 16'hFFFF;
    repeat (30) @(negedge clk);
    chk_eq("R11", "error held", ref_err, 1);
    err_clr = 1;
    @(negedge clk);
    err_clr = 0;
    chk_eq("R11", "error cleared", ref_err, 0);
    repeat (5) @(negedge clk);
    chk_eq("R11", "error stays clear", ref_err, 0);
  endtask

  initial begin
    t_reset;
    t_init;
    t_closed_write;
    t_hit_read;
    t_miss;
    t_banks;
    t_boundary;
    t_refresh;
    t_err;
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule